// File: doc/BRIEF.md
# Oversampling UART Receive Deserializer

This block turns an asynchronous serial line into bytes. It runs on the system clock and moves forward only when a strobe that pulses sixteen times per bit period is high. The line first passes through a two-flop synchronizer. A high-to-low transition seen on the line opens a candidate start bit. Eight strobes later the line is sampled again. If the line is still low, the frame is accepted. Each data bit, the optional parity bit and the stop bit are then sampled sixteen strobes apart, so every sample lands near the centre of its bit.

Data bits go into an 8-bit shift register, least significant bit first. Bits above the configured word length read as zero. When the stop bit has been sampled, the block raises a one-cycle valid strobe together with the byte and three tags: parity mismatch, bad stop bit and line break. Word length and parity settings are captured at each accepted falling edge and hold for the whole frame. A receive FIFO, an interrupt controller or a register file sits downstream of this block.

Top module: `uart_rx_deser`

## Requirements
- R1: After synchronous reset, `rx_valid`, `rx_data` and all three tags are 0.
- R2: A low pulse that has ended by the eighth strobe after the detected falling edge is treated as a false start. No `rx_valid` pulse is produced, and the next real frame is received normally.
- R3: `word_len` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. Data bits arrive least significant first. Bit i of the word appears at `rx_data[i]`, and the bits above the word length are 0.
- R4: When `parity_on` is 1, one parity bit follows the data. `parity_odd`=0 selects even parity, meaning data ones plus the parity bit form an even count. `parity_odd`=1 selects odd parity. `tag_parity` is 1 when the received count does not match the selected parity. When `parity_on` is 0 there is no parity bit and `tag_parity` is 0.
- R5: `tag_framing` is 1 exactly when the sampled stop bit is 0.
- R6: `tag_break` is 1 exactly when every data bit, the parity bit (if present) and the stop bit all sampled 0.
- R7: After a frame with a 0 stop bit, a line that stays low produces no further frames. Reception resumes only after the line has been seen high.
- R8: Each accepted frame produces exactly one `rx_valid` pulse, one clock cycle wide. The byte and tags are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle strobe, 16 per bit period |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| word_len | input | 2 | Data bits minus 5 (0..3) |
| parity_on | input | 1 | 1: a parity bit follows the data |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| rx_valid | output | 1 | One-cycle strobe: a frame has completed |
| rx_data | output | 8 | Received byte, zero-extended |
| tag_parity | output | 1 | Parity mismatch for this byte |
| tag_framing | output | 1 | Stop bit sampled low for this byte |
| tag_break | output | 1 | Whole frame sampled low |

## Verification
The bench aims at the following corner cases, each paired with how a wrong design would show it:

- **Short glitch.** A glitch that has ended before mid-start would make a careless design emit a spurious byte.
- **Long break.** A break held low for several frame times would make a receiver that re-arms without seeing the line high emit a stream of zero bytes.
- **5-bit words.** With the upper line bits set in stimulus, a wrong shift direction or missing zero-extension would show up as shifted or dirty bytes.
- **Parity.** Deliberately flipped parity bits under both even and odd settings expose an inverted sense or a parity check left active when parity is off.
- **Randomized frames.** These mix all settings with bad stop bits, and check that the framing and break tags separate correctly.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAIT_HI
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       par_en;
    logic       par_odd;
  } rx_cfg_t;

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d_in};
  end

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/urx_ctrl.sv
module urx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(OSR),
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             line,
  input  rx_cfg_t          cfg_in,
  output rx_cfg_t          cfg_q,
  output logic             frame_clr,
  output logic             data_we,
  output logic             par_we,
  output logic             stop_we,
  output logic [IDX_W-1:0] bit_idx
);
  localparam int MID      = OSR / 2;
  localparam int MIN_BITS = DATA_W - 3;

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             prev_hi;
  logic             at_mid;
  logic             at_end;
  logic [IDX_W-1:0] last_idx;

  assign at_mid   = (cnt == CNT_W'(MID - 1));
  assign at_end   = (cnt == CNT_W'(OSR - 1));
  assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_q.len_sel);

  assign frame_clr = tick && (state == ST_START) && at_mid && !line;
  assign data_we   = tick && (state == ST_DATA)  && at_end;
  assign par_we    = tick && (state == ST_PAR)   && at_end;
  assign stop_we   = tick && (state == ST_STOP)  && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      prev_hi <= 1'b1;
      cfg_q   <= '0;
    end else if (tick) begin
      prev_hi <= line;
      case (state)
        ST_IDLE: begin
          if (prev_hi && !line) begin
            state <= ST_START;
            cnt   <= '0;
            cfg_q <= cfg_in;
          end
        end
        ST_START: begin
          if (at_mid) begin
            cnt     <= '0;
            bit_idx <= '0;
            state   <= line ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (at_end) begin
            cnt <= '0;
            if (bit_idx == last_idx) state <= cfg_q.par_en ? ST_PAR : ST_STOP;
            else                     bit_idx <= bit_idx + IDX_W'(1);
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_PAR: begin
          if (at_end) begin
            cnt   <= '0;
            state <= ST_STOP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (at_end) begin
            cnt   <= '0;
            state <= line ? ST_IDLE : ST_WAIT_HI;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WAIT_HI: begin
          if (line) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a start candidate seen high at mid-bit returns to idle
  p_false_start_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && state == ST_START && at_mid && line) |=> state == ST_IDLE);

  // R3: the data phase is only ever entered from a validated start
  p_data_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && $past(state) != ST_DATA) |-> $past(state) == ST_START);

  // R5 / R7: a low stop bit parks the receiver until the line rises
  p_stop_low_r5: assert property (@(posedge clk) disable iff (rst)
    (stop_we && !line) |=> state == ST_WAIT_HI);

  p_hold_low_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_HI && !line) |=> state == ST_WAIT_HI);

  // R8: at most one sampling strobe per cycle
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_clr, data_we, par_we, stop_we}));
endmodule

// File: rtl/urx_shift.sv
module urx_shift
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  rx_cfg_t           cfg,
  input  logic              frame_clr,
  input  logic              data_we,
  input  logic              par_we,
  input  logic              stop_we,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              smp,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte,
  output logic              err_par,
  output logic              err_frm,
  output logic              err_brk
);
  localparam int MIN_BITS = DATA_W - 3;

  logic [DATA_W-1:0] sr;
  logic              par_acc;
  logic              all_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr        <= '0;
      par_acc   <= 1'b0;
      all_zero  <= 1'b1;
      out_valid <= 1'b0;
      out_byte  <= '0;
      err_par   <= 1'b0;
      err_frm   <= 1'b0;
      err_brk   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (frame_clr) begin
        sr       <= '0;
        par_acc  <= 1'b0;
        all_zero <= 1'b1;
      end
      if (data_we) begin
        sr[bit_idx] <= smp;
        par_acc     <= par_acc ^ smp;
        all_zero    <= all_zero & ~smp;
      end
      if (par_we) begin
        par_acc  <= par_acc ^ smp;
        all_zero <= all_zero & ~smp;
      end
      if (stop_we) begin
        out_valid <= 1'b1;
        out_byte  <= sr;
        err_par   <= cfg.par_en & (par_acc ^ cfg.par_odd);
        err_frm   <= ~smp;
        err_brk   <= all_zero & ~smp;
      end
    end
  end

  // R8: valid never lasts two cycles
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6: a break carries a zero byte and a framing error
  p_break_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && err_brk) |-> (err_frm && out_byte == '0));

  // R3: bits above the configured word length are zero
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_byte >> (MIN_BITS + int'(cfg.len_sel))) == '0));

  // R4: no parity tag while parity is off
  p_no_parity_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cfg.par_en) |-> !err_par);
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rx_in,
  input  logic [1:0]        word_len,
  input  logic              parity_on,
  input  logic              parity_odd,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              tag_parity,
  output logic              tag_framing,
  output logic              tag_break
);
  localparam int IDX_W = $clog2(DATA_W);

  logic             line_s;
  rx_cfg_t          cfg_in;
  rx_cfg_t          cfg_q;
  logic             frame_clr;
  logic             data_we;
  logic             par_we;
  logic             stop_we;
  logic [IDX_W-1:0] bit_idx;

  assign cfg_in = '{len_sel: word_len, par_en: parity_on, par_odd: parity_odd};

  urx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (rx_in),
    .q_out (line_s)
  );

  urx_ctrl #(.OSR(OSR), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick16),
    .line      (line_s),
    .cfg_in    (cfg_in),
    .cfg_q     (cfg_q),
    .frame_clr (frame_clr),
    .data_we   (data_we),
    .par_we    (par_we),
    .stop_we   (stop_we),
    .bit_idx   (bit_idx)
  );

  urx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg_q),
    .frame_clr (frame_clr),
    .data_we   (data_we),
    .par_we    (par_we),
    .stop_we   (stop_we),
    .bit_idx   (bit_idx),
    .smp       (line_s),
    .out_valid (rx_valid),
    .out_byte  (rx_data),
    .err_par   (tag_parity),
    .err_frm   (tag_framing),
    .err_brk   (tag_break)
  );
endmodule

// File: tb/uart_rx_deser_bench.sv
module uart_rx_deser_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rx_in = 1'b1;
  logic [1:0] word_len = 2'd3;
  logic       parity_on = 1'b0;
  logic       parity_odd = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       tag_parity, tag_framing, tag_break;

  int n_chk = 0;
  int n_fail = 0;
  int got_cnt = 0;
  int wide_valid = 0;
  bit done = 1'b0;
  bit prev_valid = 1'b0;
  logic [10:0] got_word;
  event tick_ev;

  uart_rx_deser u_uart_rx_deser (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_in(rx_in),
    .word_len(word_len), .parity_on(parity_on), .parity_odd(parity_odd),
    .rx_valid(rx_valid), .rx_data(rx_data), .tag_parity(tag_parity),
    .tag_framing(tag_framing), .tag_break(tag_break)
  );

  always #2 clk = ~clk;

  initial begin
    int tc;
    tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      tick16 = (tc % 4 == 0);
      if (tick16) -> tick_ev;
    end
  end

  always @(negedge clk) begin
    if (rx_valid) begin
      got_cnt++;
      got_word = {rx_data, tag_parity, tag_framing, tag_break};
      if (prev_valid) wide_valid++;
    end
    prev_valid = rx_valid;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) @(tick_ev);
  endtask

  function automatic logic [10:0] expect_word(input logic [7:0] d, input logic [1:0] ls,
      input bit pen, input bit podd, input bit pbit, input bit stopb);
    logic [7:0] m;
    bit pe, fe, be;
    m  = 8'hFF >> (3 - ls);
    pe = pen && ((^(d & m)) ^ pbit ^ podd);
    fe = !stopb;
    be = ((d & m) == 8'h00) && (!pen || !pbit) && !stopb;
    return {d & m, pe, fe, be};
  endfunction

  task automatic send_frame(input logic [7:0] d, input logic [1:0] ls, input bit pen,
      input bit podd, input bit flip, input bit stopb, input string req);
    int base;
    bit pbit;
    logic [10:0] exp;
    base = got_cnt;
    word_len = ls; parity_on = pen; parity_odd = podd;
    pbit = (^(d & (8'hFF >> (3 - ls)))) ^ podd ^ flip;
    rx_in = 1'b0; wait_ticks(16);
    for (int i = 0; i < 5 + int'(ls); i++) begin
      rx_in = d[i]; wait_ticks(16);
    end
    if (pen) begin rx_in = pbit; wait_ticks(16); end
    rx_in = stopb; wait_ticks(16);
    rx_in = 1'b1; wait_ticks(20);
    exp = expect_word(d, ls, pen, podd, pbit, stopb);
    check(got_cnt == base + 1, {req, " R8 frame count"}, got_cnt - base, 1);
    check(got_word == exp, {req, " byte/tags {data,par,frm,brk}"}, {21'd0, got_word}, {21'd0, exp});
  endtask

  initial begin
    int base;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({rx_valid, rx_data, tag_parity, tag_framing, tag_break} == 12'h0, "R1 reset state",
          {rx_valid, rx_data, tag_parity, tag_framing, tag_break}, 0);
    wait_ticks(20);

    send_frame(8'hA5, 2'd3, 0, 0, 0, 1, "R3 8-bit 0xA5");
    send_frame(8'hF3, 2'd0, 0, 0, 0, 1, "R3 5-bit zero-ext");
    send_frame(8'hC6, 2'd1, 0, 0, 0, 1, "R3 6-bit");
    send_frame(8'h5A, 2'd3, 1, 0, 0, 1, "R4 even good");
    send_frame(8'h5B, 2'd3, 1, 0, 1, 1, "R4 even bad");
    send_frame(8'h37, 2'd2, 1, 1, 0, 1, "R4 odd good");
    send_frame(8'h01, 2'd3, 1, 1, 1, 1, "R4 odd bad");
    send_frame(8'h81, 2'd3, 0, 0, 0, 0, "R5 low stop");
    send_frame(8'h00, 2'd3, 1, 0, 0, 0, "R6 zero frame parity");

    // R2: glitch ending before mid-start
    base = got_cnt;
    rx_in = 1'b0; wait_ticks(4);
    rx_in = 1'b1; wait_ticks(60);
    check(got_cnt == base, "R2 false start produced no byte", got_cnt - base, 0);
    send_frame(8'h3C, 2'd3, 0, 0, 0, 1, "R2 frame after glitch");

    // R6/R7: long break, one frame only
    base = got_cnt;
    word_len = 2'd3; parity_on = 1'b0;
    rx_in = 1'b0; wait_ticks(16 * 40);
    check(got_cnt == base + 1, "R7 single frame during long break", got_cnt - base, 1);
    check(got_word == 11'b00000000_011, "R6 break tags", {21'd0, got_word}, 11'h003);
    rx_in = 1'b1; wait_ticks(20);
    send_frame(8'h96, 2'd3, 0, 0, 0, 1, "R7 recovery after break");

    // random mix
    for (int k = 0; k < 110; k++) begin
      logic [7:0] d;
      logic [1:0] ls;
      bit pen, podd, flip, stopb;
      d = 8'($urandom);
      if ($urandom % 8 == 0) d = 8'h00;
      ls = 2'($urandom);
      pen = 1'($urandom);
      podd = 1'($urandom);
      flip = ($urandom % 6 == 0);
      stopb = ($urandom % 8 != 0);
      send_frame(d, ls, pen, podd, flip, stopb, "R3 R4 R5 R6 random");
    end

    check(wide_valid == 0, "R8 valid pulse one cycle", wide_valid, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule